// File: doc/BRIEF.md
# Per-Operand Binary-Point Fixed-Point ALU

This block does arithmetic on 8-bit signed fixed-point numbers. The binary point is not fixed in hardware. Each operand has its own fraction-bit count, and so does the result. A neural-network datapath can therefore give every layer its own integer/fraction split. The split is chosen ahead of time, and the unit only applies whatever counts it is given on each cycle.

Four operations are provided:

- multiply
- add
- arithmetic scaling by a power of two
- rectification (ReLU)

For every operation, the exact intermediate value is moved to the requested output format. Bits dropped on the right are truncated toward negative infinity. A value that does not fit in 8 signed bits is clamped, and a flag reports the clamp. The result is computed combinationally and captured in one output register.

Top module: `dfx_alu`

## Requirements
- R1: With `opcode` = 2'd0 (multiply), the full signed product of `op_a` and `op_b` has `frac_a + frac_b` fraction bits and is moved to `frac_out` fraction bits. Example: 0x3A with 4 fraction bits times 0x60 with 5 fraction bits, at 3 output fraction bits, gives 0x57.
- R2: With `opcode` = 2'd1 (add), the operand with fewer fraction bits is first shifted left to match the larger fraction count. The two values are then added exactly, and the sum is moved to `frac_out`.
- R3: With `opcode` = 2'd2 (scale), `op_b[3:0]` is a two's-complement count n from -8 to 7, and the result is `op_a` times 2^n in the output format. Bits `op_b[7:4]` have no effect.
- R4: With `opcode` = 2'd3 (ReLU), a negative `op_a` gives 0. A non-negative `op_a` is moved from `frac_a` to `frac_out`.
- R5: When the output format has fewer fraction bits than the intermediate value, the dropped bits are truncated toward negative infinity. For example, -0.5 gives -1 in an integer output format.
- R6: A result above 127 or below -128 in output units becomes 0x7F or 0x80 respectively, and `sat` is 1. Otherwise `sat` is 0.
- R7: The outputs change only at a rising clock edge. They reflect the inputs present just before that edge, one cycle of latency, and stay unchanged while the inputs are held.
- R8: With `rst_n` low at a rising edge, `res` becomes 0x00 and `sat` becomes 0, whatever the other inputs are.
- R9: When the output format has more fraction bits than the intermediate value, the value is shifted left without any loss of precision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 2 | 0 multiply, 1 add, 2 scale, 3 ReLU |
| op_a | input | 8 | First operand, two's complement |
| frac_a | input | 3 | Fraction-bit count of `op_a` |
| op_b | input | 8 | Second operand; for scale, low four bits are the signed shift count |
| frac_b | input | 3 | Fraction-bit count of `op_b` |
| frac_out | input | 3 | Fraction-bit count of the result |
| res | output | 8 | Registered result in the output format |
| sat | output | 1 | Registered flag: the result was clamped |

## Verification
The clocked properties assume that every input holds a known 0/1 value from the first clock edge. They also assume that inputs change only between edges, so the value sampled at one edge is the one the next registered result depends on. The fraction-count ports are as wide as their legal range, so no input value is illegal, and the properties make no assumption about their contents. The bench drives all inputs on the falling edge from time zero, with reset asserted. Its vectors and directed cases use legal encodings only.

// File: rtl/dfx_pkg.sv
// dfx_pkg: shared operation encoding for the fixed-point ALU.
// Assumes a 2-bit opcode field; every code is defined.
package dfx_pkg;

    typedef enum logic [1:0] {
        OP_MUL   = 2'd0,
        OP_ADD   = 2'd1,
        OP_SCALE = 2'd2,
        OP_RELU  = 2'd3
    } dfx_op_e;

endpackage

// File: rtl/dfx_mul.sv
// dfx_mul: forms the exact signed product of two operands and the left-shift
// amount that moves it from (fa+fb) fraction bits to fo fraction bits.
// Assumes EXT_W holds the product plus the largest left move (MAX_FRAC bits).
module dfx_mul #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 3,
    parameter int EXT_W  = 31,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic [FRAC_W-1:0]        fa,
    input  logic [FRAC_W-1:0]        fb,
    input  logic [FRAC_W-1:0]        fo,
    output logic signed [EXT_W-1:0]  val,
    output logic signed [SH_W-1:0]   sh
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [SH_W-1:0]   fa_x, fb_x, fo_x;

    // Full-width signed product; its fraction count is fa+fb.
    always_comb begin
        prod = $signed(a) * $signed(b);
        val  = {{(EXT_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Left-shift amount: output fraction count minus product fraction count.
    always_comb begin
        fa_x = {{(SH_W-FRAC_W){1'b0}}, fa};
        fb_x = {{(SH_W-FRAC_W){1'b0}}, fb};
        fo_x = {{(SH_W-FRAC_W){1'b0}}, fo};
        sh   = fo_x - fa_x - fb_x;
    end
endmodule

// File: rtl/dfx_add.sv
// dfx_add: aligns both operands to the larger fraction count, adds them
// exactly, and reports the shift that moves the sum to fo fraction bits.
// Assumes EXT_W exceeds DATA_W + MAX_FRAC + 1 so the aligned sum cannot wrap.
module dfx_add #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 3,
    parameter int EXT_W  = 31,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic [FRAC_W-1:0]        fa,
    input  logic [FRAC_W-1:0]        fb,
    input  logic [FRAC_W-1:0]        fo,
    output logic signed [EXT_W-1:0]  val,
    output logic signed [SH_W-1:0]   sh
);
    logic [FRAC_W-1:0]        f_max;
    logic [FRAC_W-1:0]        up_a, up_b;
    logic signed [EXT_W-1:0]  a_ext, b_ext;
    logic signed [SH_W-1:0]   fm_x, fo_x;

    // Pick the common fraction count and how far each operand must climb.
    always_comb begin
        f_max = (fa > fb) ? fa : fb;
        up_a  = f_max - fa;
        up_b  = f_max - fb;
    end

    // Sign-extend, align and sum both operands without loss.
    always_comb begin
        a_ext = {{(EXT_W-DATA_W){a[DATA_W-1]}}, a};
        b_ext = {{(EXT_W-DATA_W){b[DATA_W-1]}}, b};
        val   = (a_ext <<< up_a) + (b_ext <<< up_b);
    end

    // Left-shift amount from the common format to the output format.
    always_comb begin
        fm_x = {{(SH_W-FRAC_W){1'b0}}, f_max};
        fo_x = {{(SH_W-FRAC_W){1'b0}}, fo};
        sh   = fo_x - fm_x;
    end
endmodule

// File: rtl/dfx_scale.sv
// dfx_scale: single-operand path for power-of-two scaling and ReLU.
// Scaling by 2^n is folded into the shift amount instead of moving data twice.
// Assumes the count is a (FRAC_W+1)-bit two's-complement field.
module dfx_scale #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 3,
    parameter int EXT_W  = 31,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [FRAC_W:0]          count,
    input  logic [FRAC_W-1:0]        fa,
    input  logic [FRAC_W-1:0]        fo,
    input  logic                     relu_en,
    output logic signed [EXT_W-1:0]  val,
    output logic signed [SH_W-1:0]   sh
);
    logic signed [SH_W-1:0] fa_x, fo_x, cnt_x;

    // Operand value: clamped to zero when rectifying a negative input.
    always_comb begin
        if (relu_en && a[DATA_W-1]) begin
            val = '0;
        end else begin
            val = {{(EXT_W-DATA_W){a[DATA_W-1]}}, a};
        end
    end

    // Shift amount: format change plus the scaling count (count ignored for ReLU).
    always_comb begin
        fa_x  = {{(SH_W-FRAC_W){1'b0}}, fa};
        fo_x  = {{(SH_W-FRAC_W){1'b0}}, fo};
        cnt_x = relu_en ? '0 : {{(SH_W-FRAC_W-1){count[FRAC_W]}}, count};
        sh    = fo_x - fa_x + cnt_x;
    end
endmodule

// File: rtl/dfx_realign.sv
// dfx_realign: moves an exact intermediate value by a signed left-shift amount
// (negative = right, truncating toward minus infinity) and clamps it to DATA_W
// signed bits, flagging any clamp.
// Assumes |sh| never pushes significant bits out of EXT_W.
module dfx_realign #(
    parameter int DATA_W = 8,
    parameter int EXT_W  = 31,
    parameter int SH_W   = 5
) (
    input  logic signed [EXT_W-1:0] val,
    input  logic signed [SH_W-1:0]  sh,
    output logic [DATA_W-1:0]       res,
    output logic                    sat
);
    localparam logic signed [EXT_W-1:0] LIM_HI =
        {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] LIM_LO =
        {{(EXT_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic [SH_W-1:0]          amt;
    logic signed [EXT_W-1:0]  moved;
    logic                     over_hi, over_lo;

    // Shift magnitude and direction; arithmetic right shift floors.
    always_comb begin
        amt   = sh[SH_W-1] ? $unsigned(-sh) : $unsigned(sh);
        moved = sh[SH_W-1] ? (val >>> amt) : (val <<< amt);
    end

    // Range test and clamp to the signed output range.
    always_comb begin
        over_hi = moved > LIM_HI;
        over_lo = moved < LIM_LO;
        sat     = over_hi || over_lo;
        if (over_hi) begin
            res = {1'b0, {(DATA_W-1){1'b1}}};
        end else if (over_lo) begin
            res = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            res = moved[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/dfx_alu.sv
// dfx_alu: fixed-point ALU whose operands and result each carry their own
// fraction-bit count. Three arithmetic paths feed one shared realign/clamp
// stage; the clamped result and flag are registered once.
// Assumes inputs are stable around the rising edge; every code is legal.
module dfx_alu #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [FRAC_W-1:0] frac_b,
    input  logic [FRAC_W-1:0] frac_out,
    output logic [DATA_W-1:0] res,
    output logic              sat
);
    import dfx_pkg::*;

    localparam int MAX_FRAC = (1 << FRAC_W) - 1;
    localparam int EXT_W    = 2 * DATA_W + 2 * MAX_FRAC + 1;
    localparam int SH_W     = FRAC_W + 2;

    dfx_op_e                 op;
    logic signed [EXT_W-1:0] mul_v, add_v, scl_v, sel_v;
    logic signed [SH_W-1:0]  mul_s, add_s, scl_s, sel_s;
    logic [DATA_W-1:0]       res_d;
    logic                    sat_d;

    assign op = dfx_op_e'(opcode);

    dfx_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W), .SH_W(SH_W)) u_mul (
        .a(op_a), .b(op_b), .fa(frac_a), .fb(frac_b), .fo(frac_out),
        .val(mul_v), .sh(mul_s)
    );

    dfx_add #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W), .SH_W(SH_W)) u_add (
        .a(op_a), .b(op_b), .fa(frac_a), .fb(frac_b), .fo(frac_out),
        .val(add_v), .sh(add_s)
    );

    dfx_scale #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W), .SH_W(SH_W)) u_scale (
        .a(op_a), .count(op_b[FRAC_W:0]), .fa(frac_a), .fo(frac_out),
        .relu_en(op == OP_RELU), .val(scl_v), .sh(scl_s)
    );

    // Route the selected path into the shared realign stage.
    always_comb begin
        unique case (op)
            OP_MUL:  begin sel_v = mul_v; sel_s = mul_s; end
            OP_ADD:  begin sel_v = add_v; sel_s = add_s; end
            default: begin sel_v = scl_v; sel_s = scl_s; end
        endcase
    end

    dfx_realign #(.DATA_W(DATA_W), .EXT_W(EXT_W), .SH_W(SH_W)) u_realign (
        .val(sel_v), .sh(sel_s), .res(res_d), .sat(sat_d)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res <= '0;
            sat <= 1'b0;
        end else begin
            res <= res_d;
            sat <= sat_d;
        end
    end

    // Reset clears both outputs at the next edge.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !sat));

    // A clamp flag only accompanies one of the two limit codes.
    assert_sat_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (res == {1'b0, {(DATA_W-1){1'b1}}} || res == {1'b1, {(DATA_W-1){1'b0}}}));

    // Rectified results are never negative.
    assert_relu_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'd3) |=> !res[DATA_W-1]);

    // Multiplying by zero yields zero with no clamp.
    assert_mul_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'd0 && op_b == '0) |=> (res == '0 && !sat));

    // Adding zero in the operand's own format returns the operand unchanged.
    assert_add_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'd1 && op_b == '0 && frac_out == frac_a) |=> (res == $past(op_a) && !sat));

    // Scaling by 2^0 in the same format returns the operand unchanged.
    assert_scale_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'd2 && op_b[FRAC_W:0] == '0 && frac_out == frac_a) |=> (res == $past(op_a) && !sat));
endmodule

// File: tb/dfx_alu_bench.sv
module dfx_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opcode = '0;
    logic [7:0] op_a = '0, op_b = '0;
    logic [2:0] frac_a = '0, frac_b = '0, frac_out = '0;
    logic [7:0] res;
    logic       sat;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dfx_alu u_dfx_alu (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .op_a(op_a), .frac_a(frac_a), .op_b(op_b), .frac_b(frac_b),
        .frac_out(frac_out), .res(res), .sat(sat)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [2:0]  fa;
        logic [2:0]  fb;
        logic [2:0]  fo;
        logic [7:0]  er;
        logic        es;
        int unsigned req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h3A, 8'h60, 3'd4, 3'd5, 3'd3, 8'h57, 1'b0, 1},  // R1 3.625*3.0 = 10.875
        '{2'd0, 8'hFD, 8'h02, 3'd1, 3'd0, 3'd1, 8'hFA, 1'b0, 1},  // R1 -1.5*2 = -3.0
        '{2'd0, 8'h7F, 8'h7F, 3'd0, 3'd0, 3'd0, 8'h7F, 1'b1, 6},  // R6 positive clamp
        '{2'd0, 8'h80, 8'h7F, 3'd0, 3'd0, 3'd0, 8'h80, 1'b1, 6},  // R6 negative clamp
        '{2'd1, 8'h18, 8'h05, 3'd3, 3'd1, 3'd2, 8'h16, 1'b0, 2},  // R2 3.0+2.5 = 5.5
        '{2'd1, 8'h01, 8'hFF, 3'd0, 3'd7, 3'd7, 8'h7F, 1'b0, 2},  // R2 1 - 1/128, top edge no clamp
        '{2'd1, 8'h70, 8'h70, 3'd0, 3'd0, 3'd0, 8'h7F, 1'b1, 6},  // R6 add overflow
        '{2'd1, 8'h80, 8'h80, 3'd0, 3'd0, 3'd0, 8'h80, 1'b1, 6},  // R6 add underflow
        '{2'd1, 8'hFF, 8'h00, 3'd1, 3'd1, 3'd0, 8'hFF, 1'b0, 5},  // R5 -0.5 floors to -1
        '{2'd1, 8'h03, 8'h00, 3'd1, 3'd0, 3'd0, 8'h01, 1'b0, 5},  // R5 1.5 floors to 1
        '{2'd2, 8'h03, 8'h02, 3'd0, 3'd0, 3'd0, 8'h0C, 1'b0, 3},  // R3 3 * 4
        '{2'd2, 8'hF0, 8'h0E, 3'd0, 3'd0, 3'd0, 8'hFC, 1'b0, 3},  // R3 -16 / 4
        '{2'd2, 8'h03, 8'hF1, 3'd0, 3'd0, 3'd0, 8'h06, 1'b0, 3},  // R3 upper count bits ignored
        '{2'd2, 8'h08, 8'h0F, 3'd3, 3'd0, 3'd2, 8'h02, 1'b0, 3},  // R3 1.0/2 in 2-frac format
        '{2'd2, 8'h40, 8'h01, 3'd0, 3'd0, 3'd0, 8'h7F, 1'b1, 6},  // R6 scale overflow
        '{2'd3, 8'h85, 8'h00, 3'd2, 3'd0, 3'd5, 8'h00, 1'b0, 4},  // R4 negative to zero
        '{2'd3, 8'h13, 8'h00, 3'd2, 3'd0, 3'd3, 8'h26, 1'b0, 4},  // R4 4.75 kept, 3 frac bits
        '{2'd0, 8'h03, 8'h02, 3'd0, 3'd0, 3'd4, 8'h60, 1'b0, 9}   // R9 6 moved to 4 frac bits
    };

    task automatic check(input logic [7:0] er, input logic es, input string tag);
        checks++;
        if (res !== er || sat !== es) begin
            failures++;
            $display("FAIL %s: res=%h sat=%b expected res=%h sat=%b", tag, res, sat, er, es);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] fa, input logic [2:0] fb, input logic [2:0] fo);
        opcode = o; op_a = a; op_b = b; frac_a = fa; frac_b = fb; frac_out = fo;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: res=%h sat=%b expected completion", res, sat);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: reset state with a saturating input pattern present
        drive(2'd0, 8'h7F, 8'h7F, 3'd0, 3'd0, 3'd0);
        repeat (2) @(negedge clk);
        check(8'h00, 1'b0, "R8");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].fa, VECS[i].fb, VECS[i].fo);
            @(negedge clk);
            checks++;
            if (res !== VECS[i].er || sat !== VECS[i].es) begin
                failures++;
                $display("FAIL R%0d (vector %0d): res=%h sat=%b expected res=%h sat=%b",
                         VECS[i].req, i, res, sat, VECS[i].er, VECS[i].es);
            end
        end

        // R7: new inputs do not show before the edge, then appear after it
        drive(2'd0, 8'h3A, 8'h60, 3'd4, 3'd5, 3'd3);
        #5;
        check(8'h60, 1'b0, "R7");
        @(negedge clk);
        check(8'h57, 1'b0, "R7");
        @(negedge clk);
        check(8'h57, 1'b0, "R7");

        // R8: mid-run reset clears a clamped result while inputs still clamp
        drive(2'd1, 8'h70, 8'h70, 3'd0, 3'd0, 3'd0);
        @(negedge clk);
        check(8'h7F, 1'b1, "R6");
        rst_n = 1'b0;
        @(negedge clk);
        check(8'h00, 1'b0, "R8");
        rst_n = 1'b1;
        @(negedge clk);
        check(8'h7F, 1'b1, "R6");

        // R4: zero input passes through ReLU as zero
        drive(2'd3, 8'h00, 8'h55, 3'd7, 3'd0, 3'd0);
        @(negedge clk);
        check(8'h00, 1'b0, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule